// File: doc/BRIEF.md
# Carry-Cancel Adder ALU

This block is a purely combinational 8-bit arithmetic-logic unit. Every arithmetic and bitwise operation except one goes through a single ripple-carry adder. Each bit of the adder produces two internal vectors: a propagate term, which is the XOR of the two operand bits, and an OR term. A carry-cancel control forces every carry in the chain to zero. With the carry cancelled, the sum output equals the propagate vector, which gives XOR directly. AND is then built by XORing that cancelled sum with the OR vector. NOT is built by feeding all ones into the B side of the adder with the carry cancelled. Subtraction inverts B before it enters the adder.

The surrounding processor supplies the two operands, a 4-bit operation code and its stored carry flag. The add-with-carry and subtract-with-carry operations use that flag as carry-in, so numbers wider than 8 bits can be processed one byte at a time. The processor stores the returned carry-out and zero indication itself. A logical right shift by one is handled apart from the adder. Its carry-out is the bit shifted out of A.

Top module: `carry_cancel_alu`

## Requirements
- R1: Op code 0 (ADD): `{carry_out, result}` equals A + B as a 9-bit sum. `carry_flag` is not used.
- R2: Op code 1 (SUB): `{carry_out, result}` equals A + ~B + 1. `carry_out` is 1 exactly when A >= B (carry means no borrow).
- R3: Op code 2 (ADC): `{carry_out, result}` equals A + B + `carry_flag`.
- R4: Op code 3 (SBC): `{carry_out, result}` equals A + ~B + `carry_flag`. A flag of 1 means no borrow is pending.
- R5: Op code 4 (XOR): `result` equals A ^ B, produced by cancelling every carry. `carry_out` is 0.
- R6: Op code 5 (OR): `result` equals A | B. `carry_out` is 0.
- R7: Op code 6 (AND): `result` equals A & B, produced as the cancelled sum XOR the OR vector. `carry_out` is 0.
- R8: Op code 7 (NOT): `result` equals ~A, produced as A ^ 0xFF with carries cancelled. B is ignored and `carry_out` is 0.
- R9: Op code 8 (RSH): `result` equals A shifted right by one with 0 entering bit 7. `carry_out` equals A bit 0. B is ignored.
- R10: `zero` is 1 exactly when all 8 bits of `result` are 0, for every op code.
- R11: Op codes 9 to 15 give `result` 0 and `carry_out` 0, and therefore `zero` 1.
- R12: `carry_flag` has no effect on any op code other than 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| op | input | 4 | Operation code (0 ADD, 1 SUB, 2 ADC, 3 SBC, 4 XOR, 5 OR, 6 AND, 7 NOT, 8 RSH) |
| carry_flag | input | 1 | Stored carry, used as carry-in by ADC and SBC |
| result | output | 8 | Operation result |
| carry_out | output | 1 | Adder bit-7 carry, or the bit shifted out by RSH, otherwise 0 |
| zero | output | 1 | High when result is all zeros |

## Verification
The checker re-evaluates the arithmetic identities, the logic results, the shift, the zero indication and the inert unused codes whenever the inputs change. It therefore covers R1 to R11 for every input the bench applies. R12 is a relation between two input states: the output must not differ when only the flag changes. Only the bench's scenarios can show this, by applying the same operands twice with the flag flipped. The bench also targets the carry-chain extremes: 0xFF + 0x01, 0 - 1, and a 16-bit addition and subtraction chained through the flag. These show that a full-length ripple is both produced and suppressed.

// File: rtl/carry_cancel_alu.sv
module carry_cancel_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         carry_flag,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         zero
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_ADC = 4'd2, OP_SBC = 4'd3,
                         OP_XOR = 4'd4, OP_OR  = 4'd5, OP_AND = 4'd6, OP_NOT = 4'd7,
                         OP_RSH = 4'd8;

  logic         cancel, invert_b, ones_b, cin, arith;
  logic [W-1:0] bx, prop, anyb, sum;
  logic [W:0]   c;

  always_comb begin
    cancel   = 1'b0;
    invert_b = 1'b0;
    ones_b   = 1'b0;
    cin      = 1'b0;
    arith    = 1'b0;
    case (op)
      OP_ADD: arith = 1'b1;
      OP_SUB: begin arith = 1'b1; invert_b = 1'b1; cin = 1'b1; end
      OP_ADC: begin arith = 1'b1; cin = carry_flag; end
      OP_SBC: begin arith = 1'b1; invert_b = 1'b1; cin = carry_flag; end
      OP_XOR, OP_OR, OP_AND: cancel = 1'b1;
      OP_NOT: begin cancel = 1'b1; ones_b = 1'b1; end
      default: ;
    endcase
  end

  assign bx   = ones_b ? {W{1'b1}} : (invert_b ? ~b : b);
  assign prop = a ^ bx;
  assign anyb = a | bx;
  assign c[0] = cin & ~cancel;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign c[i+1] = cancel ? 1'b0 : ((prop[i] ^ anyb[i]) | (prop[i] & c[i]));
    assign sum[i] = prop[i] ^ c[i];
  end

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_ADC, OP_SBC, OP_XOR, OP_NOT: result = sum;
      OP_OR:   result = anyb;
      OP_AND:  result = sum ^ anyb;
      OP_RSH:  result = {1'b0, a[W-1:1]};
      default: result = '0;
    endcase
  end

  assign carry_out = arith ? c[W] : ((op == OP_RSH) & a[0]);
  assign zero      = ~|result;
endmodule

// File: rtl/carry_cancel_alu_chk.sv
module carry_cancel_alu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   op,
  input logic         carry_flag,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         zero
);
  always_comb begin
    if (op == 4'd0) AST_ADD_SUM: assert ({carry_out, result} == ({1'b0, a} + {1'b0, b})); // R1
    if (op == 4'd1) AST_SUB_NOBORROW: assert (carry_out == (a >= b) && result == W'(a - b)); // R2
    if (op == 4'd2) AST_ADC_SUM: assert ({carry_out, result} == ({1'b0, a} + {1'b0, b} + (W+1)'(carry_flag))); // R3
    if (op == 4'd3) AST_SBC_SUM: assert ({carry_out, result} == ({1'b0, a} + {1'b0, ~b} + (W+1)'(carry_flag))); // R4
    if (op == 4'd4) AST_XOR_CANCEL: assert (result == (a ^ b) && !carry_out); // R5
    if (op == 4'd5) AST_OR_VEC: assert (result == (a | b) && !carry_out); // R6
    if (op == 4'd6) AST_AND_VEC: assert (result == (a & b) && !carry_out); // R7
    if (op == 4'd7) AST_NOT_VEC: assert (result == ~a && !carry_out); // R8
    if (op == 4'd8) AST_RSH_OUT: assert (result == (a >> 1) && carry_out == a[0]); // R9
    AST_ZERO_FLAG: assert (zero == (result == '0)); // R10
    if (op > 4'd8) AST_UNUSED_IDLE: assert (result == '0 && !carry_out && zero); // R11
  end
endmodule

bind carry_cancel_alu carry_cancel_alu_chk #(.W(W)) u_chk (.*);

// File: tb/sim_carry_cancel_alu.sv
module sim_carry_cancel_alu;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] a, b, result;
  logic [3:0] op;
  logic       carry_flag, carry_out, zero;
  int total = 0, bad = 0;
  logic [7:0] pats [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 8'h0F};

  carry_cancel_alu u0 (.a(a), .b(b), .op(op), .carry_flag(carry_flag),
                       .result(result), .carry_out(carry_out), .zero(zero));

  function automatic logic [8:0] model(input logic [3:0] o, input logic [7:0] x, y, input logic f);
    case (o)
      4'd0: return {1'b0, x} + {1'b0, y};
      4'd1: return {1'b0, x} + {1'b0, ~y} + 9'd1;
      4'd2: return {1'b0, x} + {1'b0, y} + {8'd0, f};
      4'd3: return {1'b0, x} + {1'b0, ~y} + {8'd0, f};
      4'd4: return {1'b0, x ^ y};
      4'd5: return {1'b0, x | y};
      4'd6: return {1'b0, x & y};
      4'd7: return {1'b0, ~x};
      4'd8: return {x[0], 1'b0, x[7:1]};
      default: return 9'd0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [7:0] x, y, input logic f);
    @(posedge clk);
    op = o; a = x; b = y; carry_flag = f;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [7:0] er, input logic ec);
    total++;
    if (result !== er || carry_out !== ec || zero !== (er == 8'd0)) begin
      bad++;
      $display("FAIL %s op=%0d a=%h b=%h cf=%b: got res=%h c=%b z=%b exp res=%h c=%b z=%b",
               req, op, a, b, carry_flag, result, carry_out, zero, er, ec, (er == 8'd0));
    end
  endtask

  task automatic sweep(input string req, input logic [3:0] o);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 2; k++) begin
          logic [8:0] e;
          e = model(o, pats[i], pats[j], k[0]);
          apply(o, pats[i], pats[j], k[0]);
          expect_out(req, e[7:0], e[8]);
        end
  endtask

  task automatic t_idle_start;
    apply(4'd0, 8'h00, 8'h00, 1'b0);
    expect_out("R10", 8'h00, 1'b0);
  endtask

  task automatic t_add;
    sweep("R1", 4'd0);
    apply(4'd0, 8'hFF, 8'h01, 1'b1);
    expect_out("R1", 8'h00, 1'b1);
  endtask

  task automatic t_sub;
    sweep("R2", 4'd1);
    apply(4'd1, 8'h00, 8'h01, 1'b0);
    expect_out("R2", 8'hFF, 1'b0);
    apply(4'd1, 8'h42, 8'h42, 1'b0);
    expect_out("R2", 8'h00, 1'b1);
  endtask

  task automatic t_wide;
    apply(4'd0, 8'hF0, 8'h20, 1'b0);
    expect_out("R1", 8'h10, 1'b1);
    apply(4'd2, 8'h12, 8'h01, carry_out);
    expect_out("R3", 8'h14, 1'b0);
    apply(4'd1, 8'h00, 8'h01, 1'b0);
    expect_out("R2", 8'hFF, 1'b0);
    apply(4'd3, 8'h01, 8'h00, carry_out);
    expect_out("R4", 8'h00, 1'b1);
    sweep("R3", 4'd2);
    sweep("R4", 4'd3);
  endtask

  task automatic t_logic;
    sweep("R5", 4'd4);
    sweep("R6", 4'd5);
    sweep("R7", 4'd6);
    sweep("R8", 4'd7);
    apply(4'd7, 8'hFF, 8'h00, 1'b0);
    expect_out("R8", 8'h00, 1'b0);
  endtask

  task automatic t_shift;
    sweep("R9", 4'd8);
    apply(4'd8, 8'h01, 8'hFF, 1'b0);
    expect_out("R9", 8'h00, 1'b1);
  endtask

  task automatic t_unused;
    for (int o = 9; o < 16; o++) begin
      apply(4'(o), 8'hFF, 8'hFF, 1'b1);
      expect_out("R11", 8'h00, 1'b0);
    end
  endtask

  task automatic t_flag_ignored;
    for (int o = 0; o < 9; o++) begin
      if (o == 2 || o == 3) continue;
      for (int k = 0; k < 2; k++) begin
        logic [8:0] e;
        e = model(4'(o), 8'hA7, 8'h5C, 1'b0);
        apply(4'(o), 8'hA7, 8'h5C, k[0]);
        expect_out("R12", e[7:0], e[8]);
      end
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    op = 4'd0; a = 8'd0; b = 8'd0; carry_flag = 1'b0;
    t_idle_start();
    t_add();
    t_sub();
    t_wide();
    t_logic();
    t_shift();
    t_unused();
    t_flag_ignored();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule